// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned W-bit operands and returns a 2W-bit product, handling one bit of the multiplier per pass through a small loop. A five-state controller drives a datapath made of four parts: a register that holds the multiplicand, an accumulator with a carry flop above it, a shift register that holds the multiplier, and a bit counter. On each pass the controller tests the low bit of the shift register. It adds the multiplicand into the accumulator only when that bit is set. It then shifts the carry, accumulator and shift register right together as one word.

A client raises `start` for one cycle while the block is idle and holds both operands steady until `done` rises. The upper product half comes from the accumulator and the lower half from the shift register. Both halves stay readable until the next start. The run time depends on the data: every multiplier bit costs two cycles, plus one more for each bit that is set.

Top module: `shiftadd_mult`

## Requirements
- R1: After reset the controller waits in Idle with `product` equal to 0, and it stays there for as long as `start` is low.
- R2: When `start` is high in Idle, the controller enters the load state at the next edge. The operands are captured at the edge that ends the load state.
- R3: The load state copies the multiplicand into its holding register and the multiplier into the shift register. It clears the accumulator, the carry and the bit counter, then moves to the bit-test state.
- R4: The bit-test state goes to the add state when the shift register's bit 0 is 1, and to the shift state when that bit is 0.
- R5: The add state writes the sum of accumulator and multiplicand into the accumulator, with the carry-out into the carry flop, and always moves to the shift state next.
- R6: The shift state moves {carry, accumulator, shift register} right by one bit with 0 entering at the top, and increments the counter. After the W-th shift it returns to Idle; otherwise it goes back to bit-test.
- R7: When `done` rises, `product` equals the unsigned product of the two operands, for every operand pair.
- R8: `done` rises exactly 2 + 2W + popcount(multiplier) clock edges after the edge that sampled `start`, counting that edge.
- R9: `done` stays low from reset until the first product completes. It goes low at the edge that accepts a start and comes back high only when the block returns to Idle.
- R10: A `start` raised while the block is busy is ignored. The operation in flight keeps its result and its timing, even if the operand inputs change at the same time.
- R11: While the block sits in Idle with `start` low, `product` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication (honoured only in Idle) |
| mcand | input | W | Multiplicand, held until `done` |
| mplier | input | W | Multiplier, held until `done` |
| product | output | 2W | {accumulator, shift register} |
| done | output | 1 | High in Idle once a product is complete |

## Verification
The bench builds the block with W = 4. At that width all 256 operand pairs can be run, so it covers the largest product (15 × 15), every accumulator carry-out and every popcount from 0 to 4. The scoreboard therefore checks both the product and the cycle count that depends on the data, for each pair. Separate runs cover the quiet state after reset, a product held through a long stretch of idle cycles, and a second start with different operands pulsed in the middle of an operation.

// File: rtl/shiftadd_pkg.sv
package shiftadd_pkg;
  typedef enum logic [2:0] {
    SA_IDLE  = 3'd0,
    SA_LOAD  = 3'd1,
    SA_TEST  = 3'd2,
    SA_ADD   = 3'd3,
    SA_SHIFT = 3'd4
  } sa_state_e;
endpackage

// File: rtl/sam_bitcnt.sv
module sam_bitcnt #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          at_last
);
  logic [CW-1:0] cnt_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_r <= '0;
    else if (clr) cnt_r <= '0;
    else if (inc) cnt_r <= cnt_r + CW'(1);
  end

  // the shift performed while this is high will be the W-th one
  assign at_last = (cnt_r == CW'(W - 1));
  assign cnt     = cnt_r;
endmodule

// File: rtl/sam_datapath.sv
module sam_datapath #(
  parameter int W = 8,
  localparam int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          add_en,
  input  logic          shift_en,
  input  logic [W-1:0]  mcand,
  input  logic [W-1:0]  mplier,
  output logic          q_lsb,
  output logic [PW-1:0] product
);
  logic [W-1:0] m_r;
  logic [W-1:0] a_r;
  logic [W-1:0] q_r;
  logic         c_r;

  function automatic logic [W:0] acc_sum(input logic [W-1:0] a, input logic [W-1:0] m);
    return {1'b0, a} + {1'b0, m};
  endfunction

  // {c, a, q} moved right one place; the carry position fills with 0
  function automatic logic [PW:0] caq_shift(input logic c, input logic [W-1:0] a,
                                            input logic [W-1:0] q);
    return {1'b0, c, a, q[W-1:1]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r <= '0;
      a_r <= '0;
      q_r <= '0;
      c_r <= 1'b0;
    end else if (load) begin
      m_r <= mcand;
      q_r <= mplier;
      a_r <= '0;
      c_r <= 1'b0;
    end else if (add_en) begin
      {c_r, a_r} <= acc_sum(a_r, m_r);
    end else if (shift_en) begin
      {c_r, a_r, q_r} <= caq_shift(c_r, a_r, q_r);
    end
  end

  assign q_lsb   = q_r[0];
  assign product = {a_r, q_r};
endmodule

// File: rtl/sam_ctrl.sv
module sam_ctrl
  import shiftadd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      q_lsb,
  input  logic      at_last,
  output sa_state_e state,
  output logic      load,
  output logic      add_en,
  output logic      shift_en,
  output logic      done
);
  sa_state_e st_r, st_nx;
  logic      done_r;

  always_comb begin
    st_nx = st_r;
    unique case (st_r)
      SA_IDLE:  if (start) st_nx = SA_LOAD;
      SA_LOAD:  st_nx = SA_TEST;
      SA_TEST:  st_nx = q_lsb ? SA_ADD : SA_SHIFT;
      SA_ADD:   st_nx = SA_SHIFT;
      SA_SHIFT: st_nx = at_last ? SA_IDLE : SA_TEST;
      default:  st_nx = SA_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r   <= SA_IDLE;
      done_r <= 1'b0;
    end else begin
      st_r <= st_nx;
      if (st_r == SA_IDLE && start)          done_r <= 1'b0;
      else if (st_r == SA_SHIFT && at_last)  done_r <= 1'b1;
    end
  end

  assign state    = st_r;
  assign load     = (st_r == SA_LOAD);
  assign add_en   = (st_r == SA_ADD);
  assign shift_en = (st_r == SA_SHIFT);
  assign done     = done_r;
endmodule

// File: rtl/shiftadd_mult.sv
module shiftadd_mult
  import shiftadd_pkg::*;
#(
  parameter int W = 8,
  localparam int PW = 2 * W,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  mcand,
  input  logic [W-1:0]  mplier,
  output logic [PW-1:0] product,
  output logic          done
);
  sa_state_e     st_w;
  logic          load_w;
  logic          add_w;
  logic          shift_w;
  logic          q_lsb_w;
  logic          last_w;
  logic [CW-1:0] cnt_w;

  sam_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .q_lsb(q_lsb_w), .at_last(last_w),
    .state(st_w), .load(load_w), .add_en(add_w), .shift_en(shift_w), .done(done)
  );

  sam_bitcnt #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(load_w), .inc(shift_w), .cnt(cnt_w), .at_last(last_w)
  );

  sam_datapath #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_n), .load(load_w), .add_en(add_w), .shift_en(shift_w),
    .mcand(mcand), .mplier(mplier), .q_lsb(q_lsb_w), .product(product)
  );
endmodule

// File: rtl/shiftadd_mult_chk.sv
module shiftadd_mult_chk
  import shiftadd_pkg::*;
#(
  parameter int W = 8,
  localparam int PW = 2 * W,
  localparam int CW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic [PW-1:0] product,
  input sa_state_e     st,
  input logic          q_lsb,
  input logic          last,
  input logic [CW-1:0] cnt
);
  a_r1_idle_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SA_IDLE && !start) |=> st == SA_IDLE);

  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SA_IDLE && start) |=> st == SA_LOAD);

  a_r3_load_to_test: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SA_LOAD) |=> (st == SA_TEST && cnt == '0));

  a_r4_bit_set_adds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SA_TEST && q_lsb) |=> st == SA_ADD);

  a_r4_bit_clear_shifts: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SA_TEST && !q_lsb) |=> st == SA_SHIFT);

  a_r5_add_then_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SA_ADD) |=> st == SA_SHIFT);

  a_r6_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SA_SHIFT && !last) |=> (cnt == $past(cnt) + CW'(1) && st == SA_TEST));

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(W));

  a_r9_done_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> st == SA_IDLE);

  a_r9_finish_raises_done: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SA_SHIFT && last) |=> (done && st == SA_IDLE));

  a_r11_idle_holds_product: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SA_IDLE && !start) |=> $stable(product));
endmodule

bind shiftadd_mult shiftadd_mult_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .product(product),
  .st(st_w), .q_lsb(q_lsb_w), .last(last_w), .cnt(cnt_w)
);

// File: tb/shiftadd_mult_bench.sv
module shiftadd_mult_bench;
  localparam int W      = 4;
  localparam int PW     = 2 * W;
  localparam int CLK_NS = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  mcand = '0;
  logic [W-1:0]  mplier = '0;
  logic [PW-1:0] product;
  logic          done;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [PW-1:0] exp_prod_q[$];
  int            exp_lat_q[$];
  bit            mon_busy = 0;
  int            mon_cnt = 0;

  always #(CLK_NS / 2) clk = ~clk;

  shiftadd_mult #(.W(W)) u_shiftadd_mult (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
    .product(product), .done(done)
  );

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // monitor: counts edges from the accepted start, pops on done
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mon_busy && start) begin
        mon_busy = 1;
        mon_cnt  = 1;
      end else if (mon_busy) begin
        mon_cnt++;
        if (done) begin
          logic [PW-1:0] ep;
          int el;
          ep = exp_prod_q.pop_front();
          el = exp_lat_q.pop_front();
          check("R7 product", product == ep, product, ep);
          check("R8 latency", mon_cnt == el, mon_cnt, el);
          mon_busy = 0;
        end
      end
    end
  end

  // driver: one operation, optionally with a start pulse while busy (R10)
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
    @(negedge clk); #1;
    mcand  = a;
    mplier = b;
    start  = 1'b1;
    exp_prod_q.push_back(PW'(a) * PW'(b));
    exp_lat_q.push_back(2 + 2 * W + $countones(b));
    @(negedge clk); #1;
    start = 1'b0;
    check("R9 done low while busy", done == 1'b0, done, 0);
    if (poke) begin
      @(negedge clk); @(negedge clk); #1;
      start  = 1'b1;
      mcand  = ~a;
      mplier = ~b;
      @(negedge clk); #1;
      start  = 1'b0;
      mcand  = a;
      mplier = b;
    end
    while (mon_busy) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 product zero after reset", product == '0, product, 0);
    check("R9 done low after reset", done == 1'b0, done, 0);
    repeat (6) @(negedge clk);
    check("R1 idle without start", done == 1'b0 && product == '0, product, 0);

    // R4 R5 R6 R7 R8: every operand pair
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        run_op(W'(a), W'(b), 1'b0);

    // R11: product and done held while idle
    run_op(4'd13, 4'd11, 1'b0);
    repeat (8) @(negedge clk);
    check("R11 product held", product == PW'(143), product, 143);
    check("R9 done held in idle", done == 1'b1, done, 1);

    // R10: start pulsed mid-operation with other operands
    run_op(4'd9, 4'd7, 1'b1);
    repeat (4) @(negedge clk);
    check("R10 no second run", done == 1'b1 && product == PW'(63), product, 63);
    run_op(4'd15, 4'd0, 1'b1);
    run_op(4'd15, 4'd15, 1'b1);
    check("R2 R3 queue drained", exp_prod_q.size() == 0, exp_prod_q.size(), 0);

    finish_run();
  end
endmodule